// File: doc/BRIEF.md
# Paired-Index Scratchpad Register File

This block is the working register store of a small 4-bit processor core. It holds sixteen 4-bit registers. The same storage can also be reached as eight 8-bit pairs, in which the even register is the high nibble and the odd register is the low nibble. Each cycle it decodes one operation from the high opcode nibble and the register field of the low opcode nibble. It sends one register to the arithmetic unit and one pair to the address and jump logic, and it performs the register-side write that the operation requires.

The operations that write are these:
- An exchange stores the accumulator into a register while the old register value is returned in the same cycle.
- An increment adds one to a register, modulo 16.
- An increment-and-test does the same increment and also flags a zero result to the branch logic.
- An immediate pair load writes the second instruction byte into a pair.
- An indirect pair load writes a program-memory byte into a pair. The byte is supplied on an input, and pair 0 is exposed so that the surrounding logic can address the memory with it.

For the two pair opcodes, bit 0 of the register field selects the variant. When the bit is clear the pair is loaded. When it is set the pair is only read out as an address or a jump target.

Top module: `scratch_regfile`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 0.
- R2: `reg_rd_o` equals the register indexed by `opa_i`, combinationally. `pair_rd_o` equals {register 2p, register 2p+1}, where p = `opa_i[3:1]`; the even register is bits 7:4.
- R3: `pair0_o` always equals {register 0, register 1}.
- R4: With `exec_i`=1, `opr_i`=0x2 and `opa_i[0]`=0, pair p takes `imm_i` at the clock edge.
- R5: With `exec_i`=1, `opr_i`=0x3 and `opa_i[0]`=0, pair p takes `rom_i` at the clock edge.
- R6: With `opr_i` equal to 0x2 or 0x3 and `opa_i[0]`=1, no register changes, whatever the values of `imm_i` and `rom_i`.
- R7: With `exec_i`=1 and `opr_i`=0x6, the indexed register becomes (old+1) mod 16, and `inc_zero_o` stays 0.
- R8: With `exec_i`=1 and `opr_i`=0x7, the indexed register becomes (old+1) mod 16. `inc_zero_o` is 1 in that same cycle exactly when the old value is 0xF.
- R9: With `exec_i`=1 and `opr_i`=0xB, `reg_rd_o` shows the old register value during the cycle, and the register takes `acc_i` at the edge.
- R10: When `exec_i`=0, or when `opr_i` is any value other than 0x2, 0x3, 0x6, 0x7 or 0xB, no register changes and `inc_zero_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe for the presented opcode |
| opr_i | input | 4 | High opcode nibble (operation) |
| opa_i | input | 4 | Low opcode nibble (register or pair field) |
| acc_i | input | 4 | Accumulator value for exchange |
| imm_i | input | 8 | Second instruction byte for immediate pair load |
| rom_i | input | 8 | Program-memory byte for indirect pair load |
| reg_rd_o | output | 4 | Selected register |
| pair_rd_o | output | 8 | Selected pair |
| pair0_o | output | 8 | Pair 0, used as the indirect address |
| inc_zero_o | output | 1 | Increment-and-test result is zero |

## Verification
The assertions assume the following about the inputs:
- At most one operation is presented per cycle.
- `opr_i` and `opa_i` are stable across the sampling edge.
- `rom_i` is already valid for the current value of `pair0_o` when an indirect load executes. The bench therefore derives `rom_i` from the pair 0 value that its own model holds.

The stimulus drives every input on the falling edge only. It sweeps all sixteen opcode values with the strobe both high and low, so that unused operations and the read-only pair variants are exercised beside the writing ones.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  localparam logic [3:0] OPR_PAIR_IMM = 4'h2;
  localparam logic [3:0] OPR_PAIR_IND = 4'h3;
  localparam logic [3:0] OPR_BUMP     = 4'h6;
  localparam logic [3:0] OPR_BUMP_TST = 4'h7;
  localparam logic [3:0] OPR_SWAP     = 4'hB;

  typedef enum logic [2:0] {
    SP_IDLE,
    SP_SWAP,
    SP_BUMP,
    SP_BUMP_TST,
    SP_LOAD_IMM,
    SP_LOAD_ROM
  } sp_op_e;
endpackage

// File: rtl/sp_decode.sv
module sp_decode
  import scratch_pkg::*;
(
  input  logic       exec_i,
  input  logic [3:0] opr_i,
  input  logic       sel_lsb_i,
  output sp_op_e     op_o
);
  always_comb begin
    op_o = SP_IDLE;
    if (exec_i) begin
      unique case (opr_i)
        OPR_PAIR_IMM: op_o = sel_lsb_i ? SP_IDLE : SP_LOAD_IMM;
        OPR_PAIR_IND: op_o = sel_lsb_i ? SP_IDLE : SP_LOAD_ROM;
        OPR_BUMP:     op_o = SP_BUMP;
        OPR_BUMP_TST: op_o = SP_BUMP_TST;
        OPR_SWAP:     op_o = SP_SWAP;
        default:      op_o = SP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sp_inc.sv
module sp_inc #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] sum_o,
  output logic          zero_o
);
  assign sum_o  = val_i + DW'(1);
  assign zero_o = (sum_o == '0);
endmodule

// File: rtl/sp_storage.sv
module sp_storage #(
  parameter int NREG = 16,
  parameter int DW   = 4,
  localparam int IW  = $clog2(NREG),
  localparam int PW  = IW - 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      nib_we_i,
  input  logic [IW-1:0]             nib_idx_i,
  input  logic [DW-1:0]             nib_wdata_i,
  input  logic                      pair_we_i,
  input  logic [PW-1:0]             pair_idx_i,
  input  logic [2*DW-1:0]           pair_wdata_i,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int PAIR = i / 2;
    localparam bit IS_HI = (i % 2) == 0;
    logic [DW-1:0] pair_half;
    assign pair_half = IS_HI ? pair_wdata_i[2*DW-1:DW] : pair_wdata_i[DW-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[i] <= '0;
      end else if (nib_we_i && nib_idx_i == IW'(i)) begin
        regs_o[i] <= nib_wdata_i;
      end else if (pair_we_i && pair_idx_i == PW'(PAIR)) begin
        regs_o[i] <= pair_half;
      end
    end
  end
endmodule

// File: rtl/scratch_regfile.sv
module scratch_regfile
  import scratch_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exec_i,
  input  logic [3:0]      opr_i,
  input  logic [IW-1:0]   opa_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [2*DW-1:0] imm_i,
  input  logic [2*DW-1:0] rom_i,
  output logic [DW-1:0]   reg_rd_o,
  output logic [2*DW-1:0] pair_rd_o,
  output logic [2*DW-1:0] pair0_o,
  output logic            inc_zero_o
);
  localparam int PW = IW - 1;

  sp_op_e                   op;
  logic [NREG-1:0][DW-1:0]  regs;
  logic [PW-1:0]            pair_idx;
  logic [DW-1:0]            inc_sum;
  logic                     inc_zero;
  logic                     nib_we, pair_we;
  logic [DW-1:0]            nib_wdata;
  logic [2*DW-1:0]          pair_wdata;

  assign pair_idx = opa_i[IW-1:1];

  sp_decode u_dec (
    .exec_i    (exec_i),
    .opr_i     (opr_i),
    .sel_lsb_i (opa_i[0]),
    .op_o      (op)
  );

  assign reg_rd_o  = regs[opa_i];
  assign pair_rd_o = {regs[{pair_idx, 1'b0}], regs[{pair_idx, 1'b1}]};
  assign pair0_o   = {regs[0], regs[1]};

  sp_inc #(.DW(DW)) u_inc (
    .val_i  (reg_rd_o),
    .sum_o  (inc_sum),
    .zero_o (inc_zero)
  );

  assign nib_we     = (op == SP_SWAP) || (op == SP_BUMP) || (op == SP_BUMP_TST);
  assign nib_wdata  = (op == SP_SWAP) ? acc_i : inc_sum;
  assign pair_we    = (op == SP_LOAD_IMM) || (op == SP_LOAD_ROM);
  assign pair_wdata = (op == SP_LOAD_IMM) ? imm_i : rom_i;
  assign inc_zero_o = (op == SP_BUMP_TST) && inc_zero;

  sp_storage #(.NREG(NREG), .DW(DW)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .nib_we_i     (nib_we),
    .nib_idx_i    (opa_i),
    .nib_wdata_i  (nib_wdata),
    .pair_we_i    (pair_we),
    .pair_idx_i   (pair_idx),
    .pair_wdata_i (pair_wdata),
    .regs_o       (regs)
  );
endmodule

// File: rtl/sp_chk.sv
module sp_chk #(
  parameter int NREG = 16,
  parameter int DW   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    exec_i,
  input logic [3:0]              opr_i,
  input logic [IW-1:0]           opa_i,
  input logic [DW-1:0]           acc_i,
  input logic [2*DW-1:0]         imm_i,
  input logic [2*DW-1:0]         rom_i,
  input logic [DW-1:0]           reg_rd_o,
  input logic [2*DW-1:0]         pair_rd_o,
  input logic [2*DW-1:0]         pair0_o,
  input logic                    inc_zero_o,
  input logic [NREG-1:0][DW-1:0] regs_i
);
  logic writes;
  assign writes = exec_i && (((opr_i == 4'h2 || opr_i == 4'h3) && !opa_i[0]) ||
                  opr_i == 4'h6 || opr_i == 4'h7 || opr_i == 4'hB);

  p_pair0_view_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opa_i[IW-1:1] == '0) |-> (pair_rd_o == pair0_o));

  p_imm_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opr_i == 4'h2 && !opa_i[0]) |=>
      ({regs_i[{$past(opa_i[IW-1:1]), 1'b0}], regs_i[{$past(opa_i[IW-1:1]), 1'b1}]} == $past(imm_i)));

  p_rom_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opr_i == 4'h3 && !opa_i[0]) |=>
      ({regs_i[{$past(opa_i[IW-1:1]), 1'b0}], regs_i[{$past(opa_i[IW-1:1]), 1'b1}]} == $past(rom_i)));

  p_pair_readonly_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((opr_i == 4'h2 || opr_i == 4'h3) && opa_i[0]) |=> $stable(regs_i));

  p_bump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (opr_i == 4'h6 || opr_i == 4'h7)) |=>
      (regs_i[$past(opa_i)] == DW'($past(reg_rd_o) + 1'b1)));

  p_zero_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_zero_o |-> (exec_i && opr_i == 4'h7 && reg_rd_o == '1));

  p_swap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opr_i == 4'hB) |=> (regs_i[$past(opa_i)] == $past(acc_i)));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !writes |=> $stable(regs_i));
endmodule

bind scratch_regfile sp_chk #(.NREG(NREG), .DW(DW)) u_sp_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .exec_i     (exec_i),
  .opr_i      (opr_i),
  .opa_i      (opa_i),
  .acc_i      (acc_i),
  .imm_i      (imm_i),
  .rom_i      (rom_i),
  .reg_rd_o   (reg_rd_o),
  .pair_rd_o  (pair_rd_o),
  .pair0_o    (pair0_o),
  .inc_zero_o (inc_zero_o),
  .regs_i     (regs)
);

// File: tb/tb_scratch_regfile.sv
`timescale 1ns/1ps
module tb_scratch_regfile;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       exec_i = 1'b0;
  logic [3:0] opr_i = '0, opa_i = '0, acc_i = '0;
  logic [7:0] imm_i = '0, rom_i = '0;
  logic [3:0] reg_rd_o;
  logic [7:0] pair_rd_o, pair0_o;
  logic       inc_zero_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int mdl[16];

  always #5 clk_i = ~clk_i;

  scratch_regfile dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mpair(int p);
    return (mdl[2*p] << 4) | mdl[2*p+1];
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // one operation: drive on falling edge, compare before rising edge, then update model
  task automatic step(string tag, bit ex, int opr, int opa, int acc, int imm);
    int p;
    @(negedge clk_i);
    exec_i = ex; opr_i = 4'(opr); opa_i = 4'(opa); acc_i = 4'(acc);
    imm_i = 8'(imm);
    rom_i = 8'(mpair(0) ^ 8'hA5);
    p = opa >> 1;
    #1;
    chk({tag, " R2 reg"}, reg_rd_o, mdl[opa]);
    chk({tag, " R2 pair"}, pair_rd_o, mpair(p));
    chk({tag, " R3 pair0"}, pair0_o, mpair(0));
    chk({tag, " R8 zflag"}, inc_zero_o, int'(ex && opr == 7 && mdl[opa] == 15));
    @(posedge clk_i);
    if (ex) begin
      case (opr)
        2: if (!opa[0]) begin mdl[2*p] = (imm >> 4) & 15; mdl[2*p+1] = imm & 15; end
        3: if (!opa[0]) begin mdl[2*p] = int'(rom_i[7:4]); mdl[2*p+1] = int'(rom_i[3:0]); end
        6, 7: mdl[opa] = (mdl[opa] + 1) % 16;
        11: mdl[opa] = acc;
        default: ;
      endcase
    end
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 16; i++) step(tag, 1'b0, 0, i, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    sweep("R1 reset");
    for (int p = 0; p < 8; p++) step("R4 imm", 1'b1, 2, 2*p, 0, 8'h31 + 17*p);
    sweep("R4 after");
    step("R7 inc", 1'b1, 6, 3, 0, 0);
    for (int k = 0; k < 20; k++) step("R7 wrap", 1'b1, 6, 9, 0, 0);
    for (int k = 0; k < 20; k++) step("R8 tst", 1'b1, 7, 14, 0, 0);
    step("R9 swap", 1'b1, 11, 5, 4'hC, 0);
    step("R9 back", 1'b1, 11, 5, 4'h2, 0);
    step("R5 rom", 1'b1, 3, 6, 0, 0);
    step("R5 rom0", 1'b1, 3, 0, 0, 0);
    step("R6 src", 1'b1, 2, 7, 0, 8'hFF);
    step("R6 jin", 1'b1, 3, 9, 0, 0);
    step("R10 noexec", 1'b0, 2, 4, 0, 8'h99);
    step("R10 noexec", 1'b0, 11, 4, 4'h7, 0);
    step("R10 other", 1'b1, 4, 4, 4'h7, 8'h99);
    sweep("R10 after");
    for (int k = 0; k < 400; k++)
      step("R10 mix", 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), int'($urandom_range(0, 255)));
    sweep("final");
    finished = 1;
    report();
  end
endmodule